// File: doc/BRIEF.md
# UART Serial Transmit Path

This block turns bytes from a host into asynchronous serial frames. A host write stores one byte. In buffered mode the byte goes into a first-in first-out store of 64 entries. In direct mode a single holding slot is used instead. Whenever the serializer is idle and a byte is waiting, the serializer takes it and sends a frame:
- a low start bit;
- 5 to 8 data bits, least-significant bit first;
- an optional even or odd parity bit;
- one or two high stop bits.

Each bit lasts a fixed number of pulses of an oversampling enable. That number is 16, or 8 in fast mode.

Two status flags tell the host how far the data has gone. The storage-empty flag shows that no byte is waiting. The line-idle flag shows that the serializer has finished the last stop bit.

A transmit interrupt is raised from these flags. In buffered mode it fires when the fill level drops below a trigger threshold. In direct mode it follows the storage-empty flag. In half-duplex mode it follows the line-idle flag instead, so that a line driver can be turned off only after the final stop bit.

Top module: `uart_tx_path`

## Requirements
- R1: After reset the serial line `txd` is high, `hold_empty` and `shift_empty` are both 1, and `irq` is 0 while `irq_en` is 0.
- R2: A frame is, in line order: one 0 start bit, then `5 + char_len` data bits least-significant first (`char_len` 0..3 selects 5..8 bits), then a parity bit when `par_en` is 1, then one 1 stop bit, then a second 1 stop bit when `two_stop` is 1. After the frame the line returns to 1.
- R3: Every bit of a frame lasts 16 cycles in which `tick` is 1, or 8 such cycles when `fast_bit` is 1.
- R4: The parity bit is the XOR of the data bits that are sent when `par_odd` is 0, and its inverse when `par_odd` is 1.
- R5: With `buf_en` at 0 the block stores one byte. A write while that byte is still waiting is ignored. `hold_empty` returns to 1 on the cycle the byte moves into the serializer.
- R6: With `buf_en` at 1 up to 64 bytes wait, and they are sent in write order. A write while 64 bytes are waiting is dropped, and the queued bytes are unchanged.
- R7: `hold_empty` is 1 exactly when no byte is waiting in the storage.
- R8: `shift_empty` falls on the cycle a byte is loaded. It rises only after the last stop bit has completed its full bit time.
- R9: `irq` is 0 whenever `irq_en` is 0. With `irq_en` at 1 and `hdx_en` at 0, `irq` equals (waiting count < `trig_lvl`) in buffered mode, and equals `hold_empty` in direct mode.
- R10: With `hdx_en` at 1, `irq` equals `irq_en` AND `shift_empty`, whatever the mode.
- R11: A byte written to an idle, empty block is stored at the write edge and loaded at the next edge. The start bit then drives `txd` low from that second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable pulse |
| fast_bit | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| buf_en | input | 1 | 1: 64-entry buffered mode, 0: single holding slot |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits |
| hdx_en | input | 1 | Half-duplex interrupt source select |
| irq_en | input | 1 | Transmit interrupt enable |
| trig_lvl | input | 7 | Buffered-mode interrupt threshold |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | No byte waiting |
| shift_empty | output | 1 | Serializer idle, last stop bit done |
| irq | output | 1 | Transmit interrupt |

## Verification
A write changes `hold_empty` one edge later. A load follows one edge after that and changes `txd` and `shift_empty` at the load edge. Each bit boundary lands on the edge that ends the 16th (or 8th) tick. `irq` follows the stored state and the control inputs in the same cycle, without a register.

The bench keeps a behavioural queue-and-bit-list model that it advances on each rising edge, using the same input values the design sees. It compares all four outputs at every falling edge. Inputs change one time unit after the falling edge, so each comparison sees settled values from a single cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_W = 12;

  // last tick index within one bit time
  function automatic logic [3:0] bit_last(input logic fast);
    return fast ? 4'd7 : 4'd15;
  endfunction

  // total bits in a frame: start + data + parity + stop(s)
  function automatic logic [3:0] frame_len(input logic [1:0] code, input logic par_en,
                                           input logic two_stop);
    return 4'd7 + {2'b00, code} + {3'b000, par_en} + {3'b000, two_stop};
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] code,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < 5 + int'(code)) p = p ^ d[i];
    end
    return p;
  endfunction

  // bit 0 leaves first; unused upper positions stay 1 (stop bits)
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input logic [1:0] code,
                                                     input logic par_en, input logic odd);
    logic [FRAME_W-1:0] f;
    logic [3:0] pidx;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 5 + int'(code)) f[i+1] = d[i];
    end
    pidx = 4'd6 + {2'b00, code};
    if (par_en) f[pidx] = parity_of(d, code, odd);
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign empty    = (count == '0);
  assign full     = single ? !empty : (count == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fast_bit,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       busy,
  output logic       bit_end,
  output logic       txd
);
  logic [FRAME_W-1:0] sreg;
  logic [3:0]         bits_left;
  logic [3:0]         tick_cnt;

  assign bit_end = busy && tick && (tick_cnt == bit_last(fast_bit));
  assign txd     = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg      <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
      busy      <= 1'b0;
    end else if (load) begin
      sreg      <= build_frame(load_data, char_len, par_en, par_odd);
      bits_left <= frame_len(char_len, par_en, two_stop);
      tick_cnt  <= '0;
      busy      <= 1'b1;
    end else if (bit_end) begin
      tick_cnt  <= '0;
      sreg      <= {1'b1, sreg[FRAME_W-1:1]};
      bits_left <= bits_left - 1'b1;
      if (bits_left == 4'd1) busy <= 1'b0;
    end else if (busy && tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // R11
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R8
  stop_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  // R8
  load_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fast_bit,
  input  logic          buf_en,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          hdx_en,
  input  logic          irq_en,
  input  logic [CW-1:0] trig_lvl,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty,
  output logic          irq
);
  logic [7:0]    head;
  logic [CW-1:0] level;
  logic          store_full, store_empty;
  logic          busy, bit_end, load;
  logic          below_trig, irq_src;

  assign load = !busy && !store_empty;

  uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
    .clk(clk), .rst_n(rst_n), .single(!buf_en),
    .push(wr_en), .push_data(wr_data),
    .pop(load), .pop_data(head),
    .count(level), .full(store_full), .empty(store_empty)
  );

  uart_tx_shifter u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_bit(fast_bit),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .load(load), .load_data(head),
    .busy(busy), .bit_end(bit_end), .txd(txd)
  );

  assign hold_empty  = store_empty;
  assign shift_empty = !busy;
  assign below_trig  = level < trig_lvl;

  always_comb begin
    if (hdx_en)      irq_src = shift_empty;
    else if (buf_en) irq_src = below_trig;
    else             irq_src = hold_empty;
  end

  assign irq = irq_en && irq_src;

  // R5
  single_load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && load) |=> hold_empty);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R7
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_full |-> !hold_empty);

endmodule

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, fast_bit = 1'b0, buf_en = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, hdx_en = 1'b0, irq_en = 1'b0;
  logic [6:0] trig_lvl = 7'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, hold_empty, shift_empty, irq;

  int checks = 0, errors = 0;
  int tick_mode = 0, tick_ctr = 0;
  bit cmp_on = 1'b0, finished = 1'b0;
  string tag = "R2";

  logic [7:0] mq[$];
  int fbits[$];
  int tcnt = 0;
  bit mbusy = 1'b0;

  always #4 clk = ~clk;

  uart_tx_path uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_bit(fast_bit), .buf_en(buf_en),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .hdx_en(hdx_en), .irq_en(irq_en), .trig_lvl(trig_lvl),
    .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  task automatic chk(input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", name, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    int cap, n, ones;
    bit wok, take;
    logic [7:0] b;
    if (!rst_n) begin
      mq.delete(); fbits.delete(); tcnt = 0; mbusy = 1'b0;
    end else begin
      cap  = buf_en ? DEPTH : 1;
      wok  = wr_en && (mq.size() < cap);
      take = !mbusy && (mq.size() > 0);
      if (mbusy && tick) begin
        tcnt++;
        if (tcnt == (fast_bit ? 8 : 16)) begin
          tcnt = 0;
          void'(fbits.pop_front());
          if (fbits.size() == 0) mbusy = 1'b0;
        end
      end
      if (take) begin
        b = mq.pop_front();
        n = 5 + int'(char_len);
        ones = 0;
        fbits.delete();
        fbits.push_back(0);
        for (int i = 0; i < n; i++) begin
          fbits.push_back(int'(b[i]));
          ones += int'(b[i]);
        end
        if (par_en) fbits.push_back(par_odd ? ((ones % 2 == 0) ? 1 : 0) : ones % 2);
        fbits.push_back(1);
        if (two_stop) fbits.push_back(1);
        mbusy = 1'b1;
        tcnt = 0;
      end
      if (wok) mq.push_back(wr_data);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int exp_irq;
    if (rst_n && cmp_on) begin
      chk({tag, " txd"}, int'(txd), mbusy ? fbits[0] : 1);
      chk("R7 hold_empty", int'(hold_empty), (mq.size() == 0) ? 1 : 0);
      chk("R8 shift_empty", int'(shift_empty), mbusy ? 0 : 1);
      if (!irq_en) exp_irq = 0;
      else if (hdx_en) exp_irq = mbusy ? 0 : 1;
      else if (buf_en) exp_irq = (mq.size() < int'(trig_lvl)) ? 1 : 0;
      else exp_irq = (mq.size() == 0) ? 1 : 0;
      chk(hdx_en ? "R10 irq" : "R9 irq", int'(irq), exp_irq);
    end
  end

  // oversampling enable generator
  always @(negedge clk) begin
    #1;
    tick_ctr++;
    case (tick_mode)
      1: tick = 1'b1;
      2: tick = (tick_ctr % 3 == 0);
      default: tick = 1'b0;
    endcase
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = b;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (mq.size() == 0 && !mbusy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 hold_empty", int'(hold_empty), 1);
    chk("R1 shift_empty", int'(shift_empty), 1);
    chk("R1 irq", int'(irq), 0);
    cmp_on = 1'b1;

    // R11 load timing, R2 R3 8-bit frame, 16 ticks per bit
    tag = "R2 R3";
    tick_mode = 1;
    #1; wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk); #1; wr_en = 1'b0;
    chk("R11 stored txd", int'(txd), 1);
    chk("R11 stored hold_empty", int'(hold_empty), 0);
    chk("R11 stored shift_empty", int'(shift_empty), 1);
    @(negedge clk);
    chk("R11 start txd", int'(txd), 0);
    chk("R11 loaded shift_empty", int'(shift_empty), 0);
    chk("R5 loaded hold_empty", int'(hold_empty), 1);
    drain();

    // R5 direct mode: one slot, extra write ignored
    tag = "R5";
    tick_mode = 0;
    put(8'h3C); put(8'h5A); put(8'hFF);
    @(negedge clk);
    chk("R5 slot held", int'(hold_empty), 0);
    tick_mode = 1;
    drain();

    // R3 fast bits, R4 even parity, 7 bits, two stops, sparse ticks
    tag = "R3 R4";
    @(negedge clk); #1;
    buf_en = 1'b1; fast_bit = 1'b1; char_len = 2'd2; par_en = 1'b1; par_odd = 1'b0;
    two_stop = 1'b1; tick_mode = 2;
    put(8'h55); put(8'h0F); put(8'h80);
    drain();

    // R4 odd parity, 5 bits
    tag = "R4";
    @(negedge clk); #1;
    fast_bit = 1'b0; char_len = 2'd0; par_odd = 1'b1; two_stop = 1'b0; tick_mode = 1;
    put(8'h1F); put(8'h00); put(8'hEA);
    drain();

    // R6 overflow and R9 trigger threshold
    tag = "R6";
    @(negedge clk); #1;
    char_len = 2'd3; par_en = 1'b0; irq_en = 1'b1; trig_lvl = 7'd8; tick_mode = 0;
    for (int i = 0; i < DEPTH + 2; i++) put(8'(i * 7 + 1));
    @(negedge clk);
    chk("R6 full hold_empty", int'(hold_empty), 0);
    chk("R9 irq above threshold", int'(irq), 0);
    tick_mode = 1;
    drain();

    // R10 half-duplex interrupt source
    tag = "R10";
    @(negedge clk); #1;
    hdx_en = 1'b1;
    put(8'hC3); put(8'h3C);
    drain();

    // R9 disabled interrupt
    tag = "R9";
    @(negedge clk); #1;
    hdx_en = 1'b0; irq_en = 1'b0;
    put(8'h77);
    @(negedge clk);
    chk("R9 irq disabled", int'(irq), 0);
    drain();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule